// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the hardware half of an interrupt in a simplified 64-bit processor model. It holds five architectural registers: stack segment, stack pointer, flags, code segment and instruction pointer. It also holds a two-bit current privilege level. When it accepts an interrupt it moves onto a kernel stack taken from a programmable register. It writes the five old register values to a synchronous stack memory port, one word per cycle. It then loads the instruction pointer and privilege level from a 256-entry handler table and clears the interrupt-enable bit (bit 9) of the flags. A return request runs the mirror sequence. It reads the five words back from the stack in reverse order and restores them, which brings the old interrupt-enable state back with the flags.

The controller is a state machine with five states. IDLE accepts requests. PUSH writes frame slots 0 to 4. VECTOR commits the handler. POP_RD issues one stack read. POP_WB writes the returned word into its register. The transitions are as follows:
- IDLE goes to PUSH on an accepted interrupt, and to POP_RD on a return made in kernel privilege.
- A return made outside kernel privilege raises a fault and the block stays in IDLE.
- PUSH goes to VECTOR after the fifth write.
- VECTOR always goes back to IDLE.
- POP_RD always goes to POP_WB.
- POP_WB goes back to POP_RD until the fifth word is written, then to IDLE.

A configuration port programs the kernel stack pointer, the handler table and the architectural registers.

Top module: `trap_frame_sequencer`

## Requirements
- R1: After reset, busy, fault and mem_req are low, all five architectural registers read zero and arch_cpl is 0.
- R2: An interrupt request is accepted only in IDLE with flags bit 9 set. A request made while busy or while bit 9 is clear causes no memory access and changes no register.
- R3: On entry the block writes five words on five consecutive cycles to kernel_sp-8, -16, -24, -32 and -40. The words are the old stack segment, stack pointer, flags, code segment and instruction pointer, in that order.
- R4: When entry ends, instruction pointer = table entry with bits 1:0 zeroed, arch_cpl = entry bits 1:0, flags = old flags with bit 9 cleared, and stack pointer = kernel_sp-40. Stack segment and code segment are unchanged. busy is high for exactly 6 cycles.
- R5: A return request in IDLE with arch_cpl = 0 reads stack_pointer, +8, +16, +24 and +32, one read every second cycle. It restores instruction pointer, code segment, flags, stack pointer and stack segment in that order, sets arch_cpl to the popped code segment bits 1:0, and holds busy high for exactly 10 cycles.
- R6: The flags restored on return carry back the saved bit 9, so interrupts are enabled again whenever the saved frame had them enabled.
- R7: A return request with arch_cpl != 0 pulses fault for exactly one cycle. It makes no memory access and changes no register.
- R8: Configuration writes take effect only while not busy. cfg_sel 0 writes the kernel stack pointer. cfg_sel 1 writes table entry cfg_idx. cfg_sel 2 writes architectural register cfg_idx (0 stack segment, 1 stack pointer, 2 flags, 3 code segment, 4 instruction pointer, 5 privilege level).
- R9: When an acceptable interrupt and a return request arrive in the same idle cycle, the interrupt wins and the first busy cycle is a stack write.
- R10: Stack reads are synchronous. mem_rdata is taken one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | 8 | Interrupt vector number |
| iret_req | input | 1 | Return-from-interrupt request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 kernel SP, 1 table, 2 register |
| cfg_idx | input | 8 | Table index or register index |
| cfg_data | input | 64 | Configuration write data |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | Stack memory write enable |
| mem_addr | output | 64 | Stack memory byte address |
| mem_wdata | output | 64 | Stack memory write data |
| mem_rdata | input | 64 | Stack memory read data, one cycle after the request |
| busy | output | 1 | Entry or return sequence in progress |
| fault | output | 1 | One-cycle pulse on a return attempted outside kernel privilege |
| arch_ss | output | 64 | Stack segment register |
| arch_sp | output | 64 | Stack pointer register |
| arch_flags | output | 64 | Flags register, bit 9 is interrupt enable |
| arch_cs | output | 64 | Code segment register |
| arch_ip | output | 64 | Instruction pointer register |
| arch_cpl | output | 2 | Current privilege level, 0 is kernel |

## Verification
The bench sweeps all 256 vectors. For each one it checks the frame addresses and contents, the handler commit and a full return. Every vector with a nonzero privilege field also gets a refused return first.
- A design that pushed the registers in a different order, or walked the stack upward, would leave wrong words at the expected addresses.
- A design that restored from the wrong slot would come back with swapped registers.
- A design that let the stack pointer increments leak into the restored value would return a shifted stack pointer.
- A design that queued masked or mid-sequence requests, or accepted configuration writes while busy, would show extra stack writes or a changed handler address.
- A design that handled a non-kernel return wrongly would show a missing or multi-cycle fault, or stack reads.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int NUM_SLOTS = 5;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PUSH   = 3'd1,
        ST_VECTOR = 3'd2,
        ST_POP_RD = 3'd3,
        ST_POP_WB = 3'd4
    } seq_state_t;

    // frame slot number equals push position
    typedef enum logic [2:0] {
        SLOT_SS = 3'd0,
        SLOT_SP = 3'd1,
        SLOT_FL = 3'd2,
        SLOT_CS = 3'd3,
        SLOT_IP = 3'd4
    } slot_t;

    localparam logic [1:0] CFG_KSTACK = 2'd0;
    localparam logic [1:0] CFG_VECTOR = 2'd1;
    localparam logic [1:0] CFG_ARCH   = 2'd2;

    localparam logic [2:0] ARCH_IDX_CPL = 3'd5;

endpackage

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
    parameter int VEC_COUNT = 256,
    parameter int DATA_W    = 64,
    parameter int VEC_W     = $clog2(VEC_COUNT)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [VEC_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [VEC_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] entry_q [VEC_COUNT];

    always_ff @(posedge clk) begin
        if (we) begin
            entry_q[waddr] <= wdata;
        end
    end

    assign rdata = entry_q[raddr];

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       iret_req,
    input  logic       if_set,
    input  logic       kernel_mode,
    output logic       busy,
    output logic       fault,
    output logic       acc_irq,
    output logic       acc_ret,
    output logic       mem_req,
    output logic       mem_we,
    output slot_t      slot,
    output logic       push_step,
    output logic       pop_step,
    output logic       pop_wb,
    output logic       commit_vec
);

    localparam logic [2:0] LAST_IDX = 3'(NUM_SLOTS - 1);

    seq_state_t state_q, state_d;
    logic [2:0] idx_q, idx_d;
    logic       fault_q, fault_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        fault_d = 1'b0;
        acc_irq = 1'b0;
        acc_ret = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (irq_req && if_set) begin
                    acc_irq = 1'b1;
                    state_d = ST_PUSH;
                    idx_d   = '0;
                end else if (iret_req) begin
                    if (kernel_mode) begin
                        acc_ret = 1'b1;
                        state_d = ST_POP_RD;
                        idx_d   = '0;
                    end else begin
                        fault_d = 1'b1;
                    end
                end
            end
            ST_PUSH: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_VECTOR;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 3'd1;
                end
            end
            ST_VECTOR: begin
                state_d = ST_IDLE;
            end
            ST_POP_RD: begin
                state_d = ST_POP_WB;
            end
            ST_POP_WB: begin
                if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    state_d = ST_POP_RD;
                    idx_d   = idx_q + 3'd1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            fault_q <= fault_d;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        push_step  = 1'b0;
        pop_step   = 1'b0;
        pop_wb     = 1'b0;
        commit_vec = 1'b0;
        slot       = slot_t'(idx_q);
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                push_step = 1'b1;
            end
            ST_VECTOR: begin
                commit_vec = 1'b1;
            end
            ST_POP_RD: begin
                mem_req  = 1'b1;
                pop_step = 1'b1;
            end
            ST_POP_WB: begin
                pop_wb = 1'b1;
                slot   = slot_t'(LAST_IDX - idx_q);
            end
            default: begin
            end
        endcase
    end

    assign busy  = (state_q != ST_IDLE);
    assign fault = fault_q;

endmodule

// File: rtl/trap_arch_state.sv
module trap_arch_state
    import trap_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int IF_BIT     = 9,
    parameter int PRIV_W     = 2,
    parameter int WORD_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ksp_we,
    input  logic              arch_we,
    input  logic [2:0]        arch_idx,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              fp_from_ksp,
    input  logic              fp_from_sp,
    input  logic              push_step,
    input  logic              pop_step,
    input  logic              pop_wb,
    input  slot_t             slot,
    input  logic [DATA_W-1:0] rdata,
    input  logic              commit_vec,
    input  logic [DATA_W-1:0] handler,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] ss,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] flags,
    output logic [DATA_W-1:0] cs,
    output logic [DATA_W-1:0] ip,
    output logic [PRIV_W-1:0] cpl
);

    localparam logic [DATA_W-1:0] STEP    = DATA_W'(WORD_BYTES);
    localparam logic [DATA_W-1:0] IF_MASK = DATA_W'(1) << IF_BIT;

    logic [DATA_W-1:0] arch_q [NUM_SLOTS];
    logic [DATA_W-1:0] ksp_q;
    logic [DATA_W-1:0] fp_q;
    logic [PRIV_W-1:0] cpl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                arch_q[i] <= '0;
            end
            ksp_q <= '0;
            fp_q  <= '0;
            cpl_q <= '0;
        end else begin
            if (ksp_we) begin
                ksp_q <= cfg_data;
            end
            if (arch_we) begin
                if (arch_idx < 3'(NUM_SLOTS)) begin
                    arch_q[arch_idx] <= cfg_data;
                end else if (arch_idx == ARCH_IDX_CPL) begin
                    cpl_q <= cfg_data[PRIV_W-1:0];
                end
            end
            if (fp_from_ksp) begin
                fp_q <= ksp_q;
            end
            if (fp_from_sp) begin
                fp_q <= arch_q[SLOT_SP];
            end
            if (push_step) begin
                fp_q <= fp_q - STEP;
            end
            if (pop_step) begin
                fp_q <= fp_q + STEP;
            end
            if (pop_wb) begin
                arch_q[slot] <= rdata;
                if (slot == SLOT_CS) begin
                    cpl_q <= rdata[PRIV_W-1:0];
                end
            end
            if (commit_vec) begin
                arch_q[SLOT_IP] <= {handler[DATA_W-1:PRIV_W], PRIV_W'(0)};
                arch_q[SLOT_FL] <= arch_q[SLOT_FL] & ~IF_MASK;
                arch_q[SLOT_SP] <= fp_q;
                cpl_q           <= handler[PRIV_W-1:0];
            end
        end
    end

    assign mem_addr  = push_step ? (fp_q - STEP) : fp_q;
    assign push_data = arch_q[slot];
    assign ss        = arch_q[SLOT_SS];
    assign sp        = arch_q[SLOT_SP];
    assign flags     = arch_q[SLOT_FL];
    assign cs        = arch_q[SLOT_CS];
    assign ip        = arch_q[SLOT_IP];
    assign cpl       = cpl_q;

endmodule

// File: rtl/trap_frame_sequencer.sv
module trap_frame_sequencer
    import trap_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int VEC_COUNT = 256,
    parameter int IF_BIT    = 9,
    parameter int PRIV_W    = 2,
    localparam int VEC_W    = $clog2(VEC_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic              iret_req,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [VEC_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              fault,
    output logic [DATA_W-1:0] arch_ss,
    output logic [DATA_W-1:0] arch_sp,
    output logic [DATA_W-1:0] arch_flags,
    output logic [DATA_W-1:0] arch_cs,
    output logic [DATA_W-1:0] arch_ip,
    output logic [PRIV_W-1:0] arch_cpl
);

    logic              acc_irq, acc_ret;
    logic              push_step, pop_step, pop_wb, commit_vec;
    slot_t             slot;
    logic [VEC_W-1:0]  vec_q;
    logic [DATA_W-1:0] handler;
    logic              cfg_ok;

    assign cfg_ok = cfg_we && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (acc_irq) begin
            vec_q <= irq_vec;
        end
    end

    trap_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .iret_req   (iret_req),
        .if_set     (arch_flags[IF_BIT]),
        .kernel_mode(arch_cpl == '0),
        .busy       (busy),
        .fault      (fault),
        .acc_irq    (acc_irq),
        .acc_ret    (acc_ret),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .slot       (slot),
        .push_step  (push_step),
        .pop_step   (pop_step),
        .pop_wb     (pop_wb),
        .commit_vec (commit_vec)
    );

    trap_vec_table #(
        .VEC_COUNT(VEC_COUNT),
        .DATA_W   (DATA_W)
    ) u_table (
        .clk  (clk),
        .we   (cfg_ok && cfg_sel == CFG_VECTOR),
        .waddr(cfg_idx),
        .wdata(cfg_data),
        .raddr(vec_q),
        .rdata(handler)
    );

    trap_arch_state #(
        .DATA_W(DATA_W),
        .IF_BIT(IF_BIT),
        .PRIV_W(PRIV_W)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ksp_we     (cfg_ok && cfg_sel == CFG_KSTACK),
        .arch_we    (cfg_ok && cfg_sel == CFG_ARCH),
        .arch_idx   (cfg_idx[2:0]),
        .cfg_data   (cfg_data),
        .fp_from_ksp(acc_irq),
        .fp_from_sp (acc_ret),
        .push_step  (push_step),
        .pop_step   (pop_step),
        .pop_wb     (pop_wb),
        .slot       (slot),
        .rdata      (mem_rdata),
        .commit_vec (commit_vec),
        .handler    (handler),
        .mem_addr   (mem_addr),
        .push_data  (mem_wdata),
        .ss         (arch_ss),
        .sp         (arch_sp),
        .flags      (arch_flags),
        .cs         (arch_cs),
        .ip         (arch_ip),
        .cpl        (arch_cpl)
    );

endmodule

// File: rtl/trap_seq_checker.sv
module trap_seq_checker #(
    parameter int DATA_W = 64,
    parameter int IF_BIT = 9,
    parameter int PRIV_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              iret_req,
    input logic              busy,
    input logic              fault,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] arch_flags,
    input logic [PRIV_W-1:0] arch_cpl
);

    AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we)) |-> (mem_addr == $past(mem_addr) - DATA_W'(8))); // R3

    AST_POP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_req && !mem_we, 2)) |-> (mem_addr == $past(mem_addr, 2) + DATA_W'(8))); // R5

    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(mem_we, 2)) |-> !arch_flags[IF_BIT]); // R4

    AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && !arch_flags[IF_BIT] && !iret_req) |=> !busy); // R2

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!busy && !mem_req)); // R7

    AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && arch_flags[IF_BIT] && iret_req) |=> (mem_req && mem_we)); // R9

    AST_MEM_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R10

    AST_KERNEL_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !mem_we) |-> $past(arch_cpl == '0)); // R5

endmodule

bind trap_frame_sequencer trap_seq_checker #(
    .DATA_W(DATA_W),
    .IF_BIT(IF_BIT),
    .PRIV_W(PRIV_W)
) u_trap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .iret_req  (iret_req),
    .busy      (busy),
    .fault     (fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .arch_flags(arch_flags),
    .arch_cpl  (arch_cpl)
);

// File: tb/trap_frame_sequencer_bench.sv
`timescale 1ns/1ps
module trap_frame_sequencer_bench;

    localparam logic [63:0] KSP     = 64'h0000_0000_0000_0200;
    localparam logic [63:0] IF_MASK = 64'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic        iret_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_idx = '0;
    logic [63:0] cfg_data = '0;
    logic        mem_req, mem_we, busy, fault;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic [63:0] arch_ss, arch_sp, arch_flags, arch_cs, arch_ip;
    logic [1:0]  arch_cpl;

    always #2.5 clk = ~clk;

    trap_frame_sequencer u_trap_frame_sequencer (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
        .iret_req(iret_req), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .fault(fault),
        .arch_ss(arch_ss), .arch_sp(arch_sp), .arch_flags(arch_flags),
        .arch_cs(arch_cs), .arch_ip(arch_ip), .arch_cpl(arch_cpl)
    );

    // stack memory model with access logs
    logic [63:0] mem_arr [128];
    logic [63:0] wlog_a [1024];
    logic [63:0] wlog_d [1024];
    logic [63:0] rlog_a [1024];
    int wcnt = 0;
    int rcnt = 0;

    always @(posedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                mem_arr[mem_addr[9:3]] <= mem_wdata;
                wlog_a[wcnt % 1024] = mem_addr;
                wlog_d[wcnt % 1024] = mem_wdata;
                wcnt = wcnt + 1;
            end else begin
                mem_rdata <= mem_arr[mem_addr[9:3]];
                rlog_a[rcnt % 1024] = mem_addr;
                rcnt = rcnt + 1;
            end
        end
    end

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] idx, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // pulse a request for one cycle, then count busy cycles
    task automatic pulse(input bit irq, input bit ret, input logic [7:0] v, output int n);
        @(negedge clk);
        irq_req = irq; iret_req = ret; irq_vec = v;
        @(negedge clk);
        irq_req = 1'b0; iret_req = 1'b0;
        n = 0;
        while (busy && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [63:0] hentry(input int v);
        return 64'h0000_0040_0000_0000 + (64'(v) << 8) + 64'(v % 4);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n, wb, rb;
        logic [63:0] e_ss, e_sp, e_fl, e_cs, e_ip;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 fault", 64'(fault), 0);
        chk("R1 mem_req", 64'(mem_req), 0);
        chk("R1 ip", arch_ip, 0);
        chk("R1 sp", arch_sp, 0);
        chk("R1 flags", arch_flags, 0);
        chk("R1 cpl", 64'(arch_cpl), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 configuration
        cfg(2'd0, 8'd0, KSP);
        for (int v = 0; v < 256; v++) cfg(2'd1, 8'(v), hentry(v));
        cfg(2'd2, 8'd4, 64'h1234);
        chk("R8 ip write", arch_ip, 64'h1234);

        // sweep every vector through entry and return
        for (int v = 0; v < 256; v++) begin
            e_ss = 64'h2b + 64'(v);
            e_sp = 64'h7000_0000 + 64'(v) * 16;
            e_fl = IF_MASK | 64'h2 | (64'(v) << 12);
            e_cs = 64'h30 + (64'(v) << 8) + 64'h3;
            e_ip = 64'h40_0000 + 64'(v) * 4;
            cfg(2'd2, 8'd0, e_ss);
            cfg(2'd2, 8'd1, e_sp);
            cfg(2'd2, 8'd2, e_fl);
            cfg(2'd2, 8'd3, e_cs);
            cfg(2'd2, 8'd4, e_ip);
            cfg(2'd2, 8'd5, 64'd3);
            wb = wcnt;
            pulse(1'b1, 1'b0, 8'(v), n);
            chk("R4 entry busy cycles", 64'(n), 6);
            chk("R3 push count", 64'(wcnt - wb), 5);
            for (int k = 0; k < 5; k++) begin
                chk("R3 push addr", wlog_a[(wb + k) % 1024], KSP - 64'(8 * (k + 1)));
            end
            chk("R3 push ss", wlog_d[(wb + 0) % 1024], e_ss);
            chk("R3 push sp", wlog_d[(wb + 1) % 1024], e_sp);
            chk("R3 push flags", wlog_d[(wb + 2) % 1024], e_fl);
            chk("R3 push cs", wlog_d[(wb + 3) % 1024], e_cs);
            chk("R3 push ip", wlog_d[(wb + 4) % 1024], e_ip);
            chk("R4 ip", arch_ip, hentry(v) & ~64'h3);
            chk("R4 cpl", 64'(arch_cpl), 64'(v % 4));
            chk("R4 flags", arch_flags, e_fl & ~IF_MASK);
            chk("R4 sp", arch_sp, KSP - 64'd40);
            chk("R4 ss", arch_ss, e_ss);
            chk("R4 cs", arch_cs, e_cs);
            if (v % 4 != 0) begin
                rb = rcnt;
                @(negedge clk);
                iret_req = 1'b1;
                @(negedge clk);
                iret_req = 1'b0;
                chk("R7 fault high", 64'(fault), 1);
                chk("R7 not busy", 64'(busy), 0);
                @(negedge clk);
                chk("R7 fault one cycle", 64'(fault), 0);
                chk("R7 no reads", 64'(rcnt - rb), 0);
                chk("R7 ip kept", arch_ip, hentry(v) & ~64'h3);
                cfg(2'd2, 8'd5, 64'd0);
            end
            rb = rcnt;
            pulse(1'b0, 1'b1, 8'd0, n);
            chk("R5 return busy cycles", 64'(n), 10);
            chk("R5 pop count", 64'(rcnt - rb), 5);
            for (int k = 0; k < 5; k++) begin
                chk("R5 pop addr", rlog_a[(rb + k) % 1024], KSP - 64'd40 + 64'(8 * k));
            end
            chk("R5 ip", arch_ip, e_ip);
            chk("R5 cs", arch_cs, e_cs);
            chk("R5 sp", arch_sp, e_sp);
            chk("R5 ss", arch_ss, e_ss);
            chk("R5 cpl", 64'(arch_cpl), 3);
            chk("R6 flags", arch_flags, e_fl);
            chk("R10 flags bit9", 64'(arch_flags[9]), 1);
        end

        // R2 masked request ignored
        cfg(2'd2, 8'd2, 64'h2);
        cfg(2'd2, 8'd4, 64'h5555);
        wb = wcnt;
        pulse(1'b1, 1'b0, 8'd4, n);
        chk("R2 masked busy", 64'(n), 0);
        chk("R2 masked writes", 64'(wcnt - wb), 0);
        chk("R2 masked ip", arch_ip, 64'h5555);

        // R2 / R8 requests and config during a sequence
        cfg(2'd2, 8'd2, IF_MASK);
        cfg(2'd2, 8'd5, 64'd0);
        wb = wcnt;
        @(negedge clk);
        irq_req = 1'b1; irq_vec = 8'd4;
        @(negedge clk);
        irq_vec = 8'd8; iret_req = 1'b1;
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 64'h400;
        @(negedge clk);
        cfg_sel = 2'd2; cfg_idx = 8'd4; cfg_data = 64'h9999;
        @(negedge clk);
        irq_req = 1'b0; iret_req = 1'b0; cfg_we = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 busy ignore writes", 64'(wcnt - wb), 5);
        chk("R8 busy ignore ip", arch_ip, hentry(4) & ~64'h3);
        pulse(1'b0, 1'b1, 8'd0, n);
        cfg(2'd2, 8'd2, IF_MASK);
        cfg(2'd2, 8'd5, 64'd0);
        wb = wcnt;
        // R9 irq wins over a simultaneous return
        pulse(1'b1, 1'b1, 8'd0, n);
        chk("R9 irq first busy", 64'(n), 6);
        chk("R9 irq first writes", 64'(wcnt - wb), 5);
        chk("R8 kernel sp kept", wlog_a[wb % 1024], KSP - 64'd8);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule